// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Drives

This block compares two divided pulse trains inside a frequency synthesizer loop. One train comes from the reference divider and the other from the feedback divider that follows the oscillator. Both trains are sampled on a common system clock. The block uses their rising edges to run a two-flag detector. A reference edge raises an "up" flag and a feedback edge raises a "down" flag. Once both flags would be set, both drop on that same clock edge. The time one flag stays set is the phase error, counted in system-clock cycles.

A single detector state drives three output styles. Two of them are tristate pump drives, and each is modelled as an enable plus a level. The passive-filter pump pushes high when the reference is ahead. The active-filter pump always has the opposite polarity. The third style is a differential pair of control levels for an external pump, and both of its lines sit high when there is no error. A lock indicator stays high while every pump pulse is short. It drops low for the part of a pulse that runs longer than a programmable window.

Both pulse inputs are expected to be synchronous to the system clock already. Analog filtering and the oscillator lie outside the block.

Top module: `pfd_pump`

## Requirements
- R1: After reset the passive and active pump enables are 0, the differential pair reads v_out=1 and r_out=1, and lock_o is 1.
- R2: A rising edge on ref_in with no pending down flag and no same-cycle rising edge on fb_in makes both pump enables 1 from the next clock, with pas_lvl=1, act_lvl=0, v_out=1 and r_out=0.
- R3: A rising edge on fb_in with no pending up flag and no same-cycle rising edge on ref_in makes both pump enables 1 from the next clock, with pas_lvl=0, act_lvl=1, v_out=0 and r_out=1.
- R4: If the lagging input's rising edge arrives N clock edges after the leading one, the pump enables stay 1 for exactly N cycles and then return to 0, with v_out=1 and r_out=1.
- R5: Rising edges on both inputs at the same clock edge produce no pump activity, and the up and down flags are never set together.
- R6: While the pumps are enabled, act_lvl is the inverse of pas_lvl.
- R7: lock_o is 1 in every cycle of a pump pulse up to LOCK_WIN cycles (default 1) and in every idle cycle. It is 0 from cycle LOCK_WIN+1 of a pulse until that pulse ends.
- R8: Only a transition from 0 to 1 counts as an edge. An input held at 1 over many clocks causes no further pump pulse after its first edge has been resolved.
- R9: A second rising edge on the leading input while its flag is still set does not restart or lengthen the pulse. The pulse still ends at the lagging input's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Divided reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| pas_en | output | 1 | Passive-filter pump drive enable (0 = high impedance) |
| pas_lvl | output | 1 | Passive-filter pump level when enabled |
| act_en | output | 1 | Active-filter pump drive enable (0 = high impedance) |
| act_lvl | output | 1 | Active-filter pump level when enabled |
| v_out | output | 1 | Differential pump control, low while feedback leads |
| r_out | output | 1 | Differential pump control, low while reference leads |
| lock_o | output | 1 | Lock indicator, pulses low on long pump pulses |

## Verification
The detector is driven with the reference leading by one, three and six cycles, and the same set is repeated with the feedback leading. This separates the polarity mapping from the width measurement and shows where the lock window starts to matter. A coincident-edge pattern shows that simultaneous edges cancel. A held-high reference shows that the block reacts to transitions and not to levels. A repeated reference edge inside an open pulse shows that an extra edge from the leading input is absorbed.

// File: rtl/pfd_pump.sv
module pfd_pump #(
  parameter int LOCK_WIN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic pas_en,
  output logic pas_lvl,
  output logic act_en,
  output logic act_lvl,
  output logic v_out,
  output logic r_out,
  output logic lock_o
);

  localparam int CNT_W = (LOCK_WIN < 1) ? 1 : $clog2(LOCK_WIN + 1);
  localparam logic [CNT_W-1:0] WIN = CNT_W'(LOCK_WIN);

  logic ref_d, fb_d;
  logic up_q, dn_q;
  logic ref_rise, fb_rise;
  logic up_set, dn_set, both;
  logic pump;
  logic [CNT_W-1:0] run_q;

  assign ref_rise = ref_in & ~ref_d;
  assign fb_rise  = fb_in & ~fb_d;
  assign up_set   = up_q | ref_rise;
  assign dn_set   = dn_q | fb_rise;
  assign both     = up_set & dn_set;
  assign pump     = up_q | dn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      fb_d  <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      ref_d <= ref_in;
      fb_d  <= fb_in;
      up_q  <= up_set & ~both;
      dn_q  <= dn_set & ~both;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_q <= '0;
    else if (!(up_set ^ dn_set))
      run_q <= '0;
    else if (!pump)
      run_q <= '0;
    else if (run_q != WIN)
      run_q <= run_q + 1'b1;
  end

  assign pas_en  = pump;
  assign act_en  = pump;
  assign pas_lvl = up_q;
  assign act_lvl = dn_q;
  assign v_out   = ~dn_q;
  assign r_out   = ~up_q;
  assign lock_o  = ~(pump && run_q == WIN);

  // R2
  ref_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_in && !ref_d && !(fb_in && !fb_d) && !dn_q)
      |=> (pas_en && pas_lvl && act_en && !act_lvl && v_out && !r_out));

  // R3
  fb_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_in && !fb_d && !(ref_in && !ref_d) && !up_q)
      |=> (pas_en && !pas_lvl && act_en && act_lvl && !v_out && r_out));

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  // R5
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_in && !ref_d && fb_in && !fb_d && !up_q && !dn_q)
      |=> (!pas_en && !act_en && v_out && r_out));

  // R6
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pas_en |-> (act_lvl != pas_lvl));

  // R7
  idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pas_en && !act_en) |-> lock_o);

  // R7
  first_cycle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pas_en) |-> lock_o);

endmodule

// File: tb/pfd_pump_tb_top.sv
`timescale 1ns/1ps
module pfd_pump_tb_top;
  localparam int LW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic pas_en, pas_lvl, act_en, act_lvl, v_out, r_out, lock_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [6:0] exp;
    string tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  pfd_pump #(.LOCK_WIN(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pas_en(pas_en), .pas_lvl(pas_lvl), .act_en(act_en), .act_lvl(act_lvl),
    .v_out(v_out), .r_out(r_out), .lock_o(lock_o)
  );

  function automatic logic [6:0] idle_v();
    return 7'b0000111;
  endfunction

  function automatic logic [6:0] up_v(int j);
    return {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, logic'(j < LW)};
  endfunction

  function automatic logic [6:0] dn_v(int j);
    return {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, logic'(j < LW)};
  endfunction

  task automatic cyc(bit r, bit f, logic [6:0] e, string tag);
    item_t it;
    @(negedge clk);
    ref_in = r;
    fb_in  = f;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic lead(int d, bit fb_first, string tag);
    for (int j = 0; j < d; j++) begin
      if (fb_first) cyc(1'b0, j == 0, dn_v(j), tag);
      else          cyc(j == 0, 1'b0, up_v(j), tag);
    end
    if (fb_first) cyc(1'b1, 1'b0, idle_v(), tag);
    else          cyc(1'b0, 1'b1, idle_v(), tag);
    cyc(1'b0, 1'b0, idle_v(), tag);
    cyc(1'b0, 1'b0, idle_v(), tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        logic [6:0] act;
        it = q.pop_front();
        act = {pas_en, pas_lvl, act_en, act_lvl, v_out, r_out, lock_o};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: outputs actual=%b expected=%b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({pas_en, act_en, v_out, r_out, lock_o} !== 5'b00111) begin
      errors++;
      $display("FAIL R1: actual=%b expected=00111", {pas_en, act_en, v_out, r_out, lock_o});
    end
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, idle_v(), "R1");
    cyc(1'b0, 1'b0, idle_v(), "R1");

    lead(1, 1'b0, "R2 R4 R7");
    lead(3, 1'b0, "R2 R4 R6 R7");
    lead(6, 1'b0, "R2 R4 R7");
    lead(1, 1'b1, "R3 R4 R7");
    lead(3, 1'b1, "R3 R4 R6 R7");
    lead(6, 1'b1, "R3 R4 R7");

    cyc(1'b1, 1'b1, idle_v(), "R5");
    cyc(1'b0, 1'b0, idle_v(), "R5");
    cyc(1'b0, 1'b0, idle_v(), "R5");

    cyc(1'b1, 1'b0, up_v(0), "R8");
    cyc(1'b1, 1'b0, up_v(1), "R8");
    cyc(1'b1, 1'b1, idle_v(), "R8");
    cyc(1'b1, 1'b1, idle_v(), "R8");
    cyc(1'b1, 1'b0, idle_v(), "R8");
    cyc(1'b1, 1'b0, idle_v(), "R8");
    cyc(1'b0, 1'b0, idle_v(), "R8");
    cyc(1'b0, 1'b0, idle_v(), "R8");

    cyc(1'b1, 1'b0, up_v(0), "R9");
    cyc(1'b0, 1'b0, up_v(1), "R9");
    cyc(1'b1, 1'b0, up_v(2), "R9");
    cyc(1'b0, 1'b0, up_v(3), "R9");
    cyc(1'b0, 1'b1, idle_v(), "R9");
    cyc(1'b0, 1'b0, idle_v(), "R9");

    cyc(1'b0, 1'b1, dn_v(0), "R9");
    cyc(1'b0, 1'b0, dn_v(1), "R9");
    cyc(1'b0, 1'b1, dn_v(2), "R9");
    cyc(1'b1, 1'b0, idle_v(), "R9");
    cyc(1'b0, 1'b0, idle_v(), "R9");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule